// File: doc/BRIEF.md
# Serial Delay-Chain Configuration Register

This block holds the delay settings of a group of I/O pins and lets them be changed at run time over a narrow serial path. Each pin owns a lane made of an 11-bit shift register and an 11-bit holding register. All lanes listen to one serial data line, one configuration clock and one update strobe. Each lane has its own enable. A lane takes in one serial bit per clock only while its enable is high. Lanes whose enable is low keep their contents.

Pulsing the shared update strobe copies every lane's shift register into its holding register in the same clock. The holding register drives three delay codes for the pin: a 4-bit input delay, a 3-bit output delay and a second 4-bit output delay. Because the outputs come from the holding register, a new setting can be shifted in while the pin keeps its current delays. The new setting then takes effect in a single step.

Top module: `dly_cfg_bank`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high on a clock edge, every lane's shift register and holding register are cleared. From the following cycle, all delay outputs read zero and stay zero until a later update.
- R2: On a clock edge where `ena[i]` is high, lane i shifts `ser_din` into bit 0 of its shift register, and each older bit moves up by one position.
- R3: On a clock edge where `ena[i]` is low, lane i's shift register is unchanged, whatever `ser_din` does. A later update therefore leaves that lane's outputs at their previous values.
- R4: After 11 shifts, the first four bits shifted in appear on the lane's `in_dly` field, with the earliest bit as its MSB (shift register bits [10:7]).
- R5: The next three bits shifted in appear on the lane's `out_dly` field, earliest bit as MSB (shift register bits [6:4]).
- R6: The final four bits shifted in appear on the lane's `out2_dly` field, earliest bit as MSB (shift register bits [3:0]).
- R7: The delay outputs change only in the cycle after `upd` is sampled high. While bits are shifted in with `upd` low, the outputs stay stable.
- R8: When `upd` and `ena[i]` are high on the same edge, lane i's holding register captures the shift register value from before that edge's shift.
- R9: When more than 11 bits are shifted in before an update, only the last 11 are kept, and older bits drop off the high end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock shared by all lanes |
| rst | input | 1 | Synchronous active-high reset |
| ser_din | input | 1 | Shared serial configuration data |
| upd | input | 1 | Shared update strobe, copies shift into holding registers |
| ena | input | NUM_PINS | Per-lane shift enable |
| in_dly | output | NUM_PINS*IN_W | Input delay code, lane i at [i*IN_W +: IN_W] |
| out_dly | output | NUM_PINS*OUT_W | Output delay code, lane i at [i*OUT_W +: OUT_W] |
| out2_dly | output | NUM_PINS*OUT2_W | Second output delay code, lane i at [i*OUT2_W +: OUT2_W] |

## Verification
The assertions check the following on every cycle: each enabled lane shifts by exactly one position with the serial bit at the bottom, idle lanes hold still, outputs stay frozen without an update, and an update presents the pre-edge shift word on the three fields in the stated bit order. Other behaviours depend on a whole sequence of cycles, so only the bench scenarios can show them. These are the mapping from arrival order to field bits across eleven shifts, the isolation of a lane that shares the bus while enabled alone, the dropping of surplus bits, and the simultaneous shift-and-update case. The bench also covers a reset issued mid-configuration.

// File: rtl/dly_cfg_pkg.sv
package dly_cfg_pkg;

  localparam int DEF_IN_W   = 4;
  localparam int DEF_OUT_W  = 3;
  localparam int DEF_OUT2_W = 4;

  typedef enum logic [1:0] {
    ACT_IDLE  = 2'b00,
    ACT_SHIFT = 2'b01,
    ACT_LOAD  = 2'b10,
    ACT_BOTH  = 2'b11
  } lane_act_e;

  function automatic lane_act_e decode_act(input logic en, input logic up);
    lane_act_e a;
    case ({up, en})
      2'b01:   a = ACT_SHIFT;
      2'b10:   a = ACT_LOAD;
      2'b11:   a = ACT_BOTH;
      default: a = ACT_IDLE;
    endcase
    return a;
  endfunction

  function automatic logic act_shifts(input lane_act_e a);
    return (a == ACT_SHIFT) || (a == ACT_BOTH);
  endfunction

  function automatic logic act_loads(input lane_act_e a);
    return (a == ACT_LOAD) || (a == ACT_BOTH);
  endfunction

endpackage

// File: rtl/dly_cfg_shreg.sv
module dly_cfg_shreg #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] push_low(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (en) begin
      q <= push_low(q, din);
    end
  end

endmodule

// File: rtl/dly_cfg_hold.sv
module dly_cfg_hold #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end

endmodule

// File: rtl/dly_cfg_split.sv
module dly_cfg_split #(
  parameter int IN_W   = 4,
  parameter int OUT_W  = 3,
  parameter int OUT2_W = 4,
  localparam int TOT_W = IN_W + OUT_W + OUT2_W
) (
  input  logic [TOT_W-1:0]  word,
  output logic [IN_W-1:0]   f_in,
  output logic [OUT_W-1:0]  f_out,
  output logic [OUT2_W-1:0] f_out2
);

  localparam int OUT2_LO = 0;
  localparam int OUT_LO  = OUT2_W;
  localparam int IN_LO   = OUT2_W + OUT_W;

  always_comb begin
    f_in   = word[IN_LO   +: IN_W];
    f_out  = word[OUT_LO  +: OUT_W];
    f_out2 = word[OUT2_LO +: OUT2_W];
  end

endmodule

// File: rtl/dly_cfg_lane.sv
module dly_cfg_lane
  import dly_cfg_pkg::*;
#(
  parameter int IN_W   = DEF_IN_W,
  parameter int OUT_W  = DEF_OUT_W,
  parameter int OUT2_W = DEF_OUT2_W,
  localparam int TOT_W = IN_W + OUT_W + OUT2_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_din,
  input  logic              upd,
  input  logic              en,
  output logic [IN_W-1:0]   f_in,
  output logic [OUT_W-1:0]  f_out,
  output logic [OUT2_W-1:0] f_out2,
  output logic [TOT_W-1:0]  sreg,
  output logic              shift_fire,
  output logic              load_fire
);

  lane_act_e           act;
  logic [TOT_W-1:0]    hold;

  always_comb begin
    act        = decode_act(en, upd);
    shift_fire = act_shifts(act);
    load_fire  = act_loads(act);
  end

  dly_cfg_shreg #(.W(TOT_W)) u_shreg (
    .clk (clk),
    .rst (rst),
    .en  (shift_fire),
    .din (ser_din),
    .q   (sreg)
  );

  dly_cfg_hold #(.W(TOT_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (load_fire),
    .d    (sreg),
    .q    (hold)
  );

  dly_cfg_split #(.IN_W(IN_W), .OUT_W(OUT_W), .OUT2_W(OUT2_W)) u_split (
    .word   (hold),
    .f_in   (f_in),
    .f_out  (f_out),
    .f_out2 (f_out2)
  );

endmodule

// File: rtl/dly_cfg_bank.sv
module dly_cfg_bank
  import dly_cfg_pkg::*;
#(
  parameter int NUM_PINS = 2,
  parameter int IN_W     = DEF_IN_W,
  parameter int OUT_W    = DEF_OUT_W,
  parameter int OUT2_W   = DEF_OUT2_W
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ser_din,
  input  logic                       upd,
  input  logic [NUM_PINS-1:0]        ena,
  output logic [NUM_PINS*IN_W-1:0]   in_dly,
  output logic [NUM_PINS*OUT_W-1:0]  out_dly,
  output logic [NUM_PINS*OUT2_W-1:0] out2_dly
);

  localparam int TOT_W = IN_W + OUT_W + OUT2_W;

  logic [NUM_PINS*TOT_W-1:0] sreg_flat;
  logic [NUM_PINS-1:0]       shift_fire;
  logic [NUM_PINS-1:0]       load_fire;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
    dly_cfg_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .OUT2_W(OUT2_W)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .ser_din    (ser_din),
      .upd        (upd),
      .en         (ena[i]),
      .f_in       (in_dly[i*IN_W +: IN_W]),
      .f_out      (out_dly[i*OUT_W +: OUT_W]),
      .f_out2     (out2_dly[i*OUT2_W +: OUT2_W]),
      .sreg       (sreg_flat[i*TOT_W +: TOT_W]),
      .shift_fire (shift_fire[i]),
      .load_fire  (load_fire[i])
    );
  end

endmodule

// File: rtl/dly_cfg_bank_chk.sv
module dly_cfg_bank_chk #(
  parameter int NUM_PINS = 2,
  parameter int IN_W     = 4,
  parameter int OUT_W    = 3,
  parameter int OUT2_W   = 4,
  localparam int TOT_W   = IN_W + OUT_W + OUT2_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       ser_din,
  input logic                       upd,
  input logic [NUM_PINS-1:0]        ena,
  input logic [NUM_PINS*IN_W-1:0]   in_dly,
  input logic [NUM_PINS*OUT_W-1:0]  out_dly,
  input logic [NUM_PINS*OUT2_W-1:0] out2_dly,
  input logic [NUM_PINS*TOT_W-1:0]  sreg_flat,
  input logic [NUM_PINS-1:0]        shift_fire,
  input logic [NUM_PINS-1:0]        load_fire
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (in_dly == '0 && out_dly == '0 && out2_dly == '0 && sreg_flat == '0)); // R1

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    AST_SHIFT_ONE: assert property (@(posedge clk) disable iff (rst)
      shift_fire[i] |=> sreg_flat[i*TOT_W +: TOT_W] ==
        {$past(sreg_flat[i*TOT_W +: TOT_W-1]), $past(ser_din)}); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !ena[i] |=> $stable(sreg_flat[i*TOT_W +: TOT_W])); // R3

    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !upd |=> ($stable(in_dly[i*IN_W +: IN_W]) && $stable(out_dly[i*OUT_W +: OUT_W]) &&
                $stable(out2_dly[i*OUT2_W +: OUT2_W]))); // R7

    AST_UPDATE_PRESHIFT: assert property (@(posedge clk) disable iff (rst)
      load_fire[i] |=> {in_dly[i*IN_W +: IN_W], out_dly[i*OUT_W +: OUT_W],
                        out2_dly[i*OUT2_W +: OUT2_W]} == $past(sreg_flat[i*TOT_W +: TOT_W])); // R8
  end

endmodule

bind dly_cfg_bank dly_cfg_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .IN_W     (IN_W),
  .OUT_W    (OUT_W),
  .OUT2_W   (OUT2_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ser_din    (ser_din),
  .upd        (upd),
  .ena        (ena),
  .in_dly     (in_dly),
  .out_dly    (out_dly),
  .out2_dly   (out2_dly),
  .sreg_flat  (sreg_flat),
  .shift_fire (shift_fire),
  .load_fire  (load_fire)
);

// File: tb/dly_cfg_bank_tb.sv
module dly_cfg_bank_tb;

  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ser_din = 1'b0;
  logic          upd = 1'b0;
  logic [NP-1:0] ena = '0;
  logic [NP*4-1:0] in_dly;
  logic [NP*3-1:0] out_dly;
  logic [NP*4-1:0] out2_dly;

  int checks = 0;
  int errors = 0;

  logic [3:0] m_in   [NP];
  logic [2:0] m_out  [NP];
  logic [3:0] m_out2 [NP];

  always #5 clk = ~clk;

  dly_cfg_bank #(.NUM_PINS(NP)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .ser_din  (ser_din),
    .upd      (upd),
    .ena      (ena),
    .in_dly   (in_dly),
    .out_dly  (out_dly),
    .out2_dly (out2_dly)
  );

  // {lane mask[1:0], bits sent first-to-last pat[10:0], in[3:0], out[2:0], out2[3:0]}
  localparam logic [23:0] VEC [6] = '{
    {2'b01, 11'b10100110110, 4'b1010, 3'b011, 4'b0110},
    {2'b10, 11'b01011001001, 4'b0101, 3'b100, 4'b1001},
    {2'b01, 11'b11111111111, 4'b1111, 3'b111, 4'b1111},
    {2'b10, 11'b00010001000, 4'b0001, 3'b000, 4'b1000},
    {2'b11, 11'b11000100011, 4'b1100, 3'b010, 4'b0011},
    {2'b01, 11'b00000000000, 4'b0000, 3'b000, 4'b0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_lanes(input string req);
    for (int l = 0; l < NP; l++) begin
      check(req, {28'd0, in_dly[l*4 +: 4]},   {28'd0, m_in[l]});
      check(req, {29'd0, out_dly[l*3 +: 3]},  {29'd0, m_out[l]});
      check(req, {28'd0, out2_dly[l*4 +: 4]}, {28'd0, m_out2[l]});
    end
  endtask

  task automatic load_bits(input logic [NP-1:0] mask, input logic [15:0] bits, input int n);
    for (int k = n - 1; k >= 0; k--) begin
      @(negedge clk);
      ena = mask;
      ser_din = bits[k];
    end
    @(negedge clk);
    ena = '0;
    ser_din = 1'b0;
  endtask

  task automatic pulse_update();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog all-R actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int l = 0; l < NP; l++) begin
      m_in[l] = '0; m_out[l] = '0; m_out2[l] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_lanes("R1 reset state");

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      logic [1:0]  msk;
      logic [10:0] pat;
      msk = VEC[v][23:22];
      pat = VEC[v][21:11];
      // feed noise on din with no lane enabled (R3)
      @(negedge clk); ser_din = 1'b1;
      @(negedge clk); ser_din = 1'b0;
      load_bits(msk, {5'd0, pat}, 11);
      check_lanes("R7 outputs frozen after shifting");
      pulse_update();
      for (int l = 0; l < NP; l++) begin
        if (msk[l]) begin
          m_in[l]   = VEC[v][10:7];
          m_out[l]  = VEC[v][6:4];
          m_out2[l] = VEC[v][3:0];
        end
      end
      check_lanes("R4 R5 R6 field split, R3 other lane unchanged");
    end

    // R9: 13 bits into lane 1, only last 11 survive
    load_bits(2'b10, 16'b0001100001110001, 13);
    pulse_update();
    m_in[1] = 4'b0000; m_out[1] = 3'b111; m_out2[1] = 4'b0001;
    check_lanes("R9 surplus bits dropped");

    // R8: update in same cycle as first shift of next word
    load_bits(2'b01, 16'b0000001101011100, 11);
    @(negedge clk);
    ena = 2'b01; ser_din = 1'b1; upd = 1'b1;
    @(negedge clk);
    ena = '0; ser_din = 1'b0; upd = 1'b0;
    m_in[0] = 4'b0110; m_out[0] = 3'b101; m_out2[0] = 4'b1100;
    check_lanes("R8 update takes pre-shift word");

    // R1: mid-configuration reset, then update with nothing shifted
    load_bits(2'b11, 16'h0155, 6);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int l = 0; l < NP; l++) begin
      m_in[l] = '0; m_out[l] = '0; m_out2[l] = '0;
    end
    check_lanes("R1 mid-run reset clears outputs");
    pulse_update();
    check_lanes("R1 shift register cleared by reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule